// File: doc/BRIEF.md
# Interrupt Control Registers and Exception Entry

This block keeps the interrupt state of a small 32-bit processor core and decides, at each instruction boundary, whether the core must leave its normal flow to serve an interrupt. It collects 32 request lines into a pending register. A mask register selects which lines may interrupt. A global enable bit, with one saved copy, gates entry. All sources share one vector that sits 0xC0 bytes above a programmable, 256-byte aligned base address.

When an interrupt is taken, the block raises a one-cycle take pulse and a redirect request toward the vector. In the same cycle it asks the register file to write the next sequential PC into general register 30, which serves as the exception address register. On the clock edge of entry it moves the global enable bit into the saved copy and clears the global enable, so a second entry cannot occur before software returns. A return-from-exception strobe restores the global enable from the saved copy and redirects to the exception address that the register file supplies. Software reads pending and mask to pick a handler. Dispatch, the pipeline and the register file are outside the block.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After a synchronous reset, all four CSRs read zero and no interrupt is taken.
- R2: A request line that is high in a cycle sets its pending bit (CSR address 2) from the next cycle on. The bit stays set after the line drops.
- R3: Writing to CSR address 2 clears each pending bit whose write-data bit is 1. If that request line is high in the same cycle, the bit stays set.
- R4: `take_irq` is high exactly when `insn_boundary` is high, the global enable is set, `eret` is low and (pending AND mask) is nonzero.
- R5: CSR address 3 holds the base address with bits 7:0 always reading zero. On a take, `redirect_pc` equals base + 0xC0.
- R6: On a take, `ea_we` is high, `ea_idx` is 30 and `ea_wdata` equals `next_pc`. `ea_we` is low otherwise.
- R7: The status CSR (address 0) holds the global enable in bit 0 and the saved enable in bit 1. On a take, the saved enable gets the old global enable and the global enable is cleared, so no further take can occur until it is set again.
- R8: An `eret` strobe copies the saved enable into the global enable. It raises `redirect_valid` with `redirect_pc` equal to `ea_value`, and it suppresses a take in the same cycle.
- R9: When a take coincides with a write to the status CSR, the entry update wins and the written value is discarded. When `eret` coincides with a status write, the restore wins.
- R10: The mask CSR (address 1) stores and reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Interrupt request lines |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR select: 0 status, 1 mask, 2 pending, 3 base |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_addr` (combinational) |
| insn_boundary | input | 1 | High when an instruction completes and an interrupt may be taken |
| next_pc | input | 32 | Address of the next sequential instruction |
| eret | input | 1 | Return-from-exception strobe |
| ea_value | input | 32 | Current content of the exception address register |
| take_irq | output | 1 | Interrupt is taken in this cycle |
| redirect_valid | output | 1 | Fetch must be redirected to `redirect_pc` |
| redirect_pc | output | 32 | Redirect target |
| ea_we | output | 1 | Write request to the exception address register |
| ea_idx | output | 5 | Register index for that write (30) |
| ea_wdata | output | 32 | Return address to save |

## Verification
Three collisions matter here. A pending clear can land in the same cycle as a request on the same line. An entry can coincide with a software write to the status CSR. A return strobe can arrive while a boundary with a serviceable interrupt is presented. Directed sequences force each collision and then read back the CSRs or watch the redirect outputs. The random phase mixes sparse requests, status writes, clears and return strobes, so these collisions also recur at random. A bench model applies the stated winners (request over clear, entry over write, return over entry) and checks every output and every read in each cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned XLEN       = 32;
    localparam int unsigned NUM_LINES  = 32;
    localparam int unsigned ALIGN_BITS = 8;
    localparam int unsigned RF_IDX_W   = 5;
    localparam logic [XLEN-1:0] VECTOR_OFFSET = 32'h0000_00C0;
    localparam logic [RF_IDX_W-1:0] EA_REG_IDX = 5'd30;

    typedef enum logic [1:0] {
        CSR_STATUS  = 2'd0,
        CSR_MASK    = 2'd1,
        CSR_PENDING = 2'd2,
        CSR_BASE    = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic saved_en;
        logic glob_en;
    } irq_status_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] target;
    } redirect_t;

    function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] v);
        return {v[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    function automatic logic [XLEN-1:0] status_word(input irq_status_t s);
        return {{(XLEN-2){1'b0}}, s.saved_en, s.glob_en};
    endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int unsigned LINES = irq_pkg::NUM_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req_i,
    input  logic             clr_we_i,
    input  logic [LINES-1:0] clr_mask_i,
    output logic [LINES-1:0] pend_o
);
    logic [LINES-1:0] pend_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else if (req_i[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_we_i && clr_mask_i[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    assert_pend_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i)));

    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr_we_i |=> ((pend_q & $past(clr_mask_i) & ~$past(req_i)) == '0));

endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
    import irq_pkg::*;
#(
    parameter int unsigned LINES = NUM_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  csr_sel_e         sel_i,
    input  logic [XLEN-1:0]  wdata_i,
    input  logic             take_i,
    input  logic             eret_i,
    output irq_status_t      status_o,
    output logic [LINES-1:0] mask_o,
    output logic [XLEN-1:0]  base_o
);
    irq_status_t      status_q;
    logic [LINES-1:0] mask_q;
    logic [XLEN-1:0]  base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (take_i) begin
            status_q.saved_en <= status_q.glob_en;
            status_q.glob_en  <= 1'b0;
        end else if (eret_i) begin
            status_q.glob_en  <= status_q.saved_en;
        end else if (we_i && sel_i == CSR_STATUS) begin
            status_q.glob_en  <= wdata_i[0];
            status_q.saved_en <= wdata_i[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (we_i && sel_i == CSR_MASK) begin
            mask_q <= wdata_i[LINES-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (we_i && sel_i == CSR_BASE) begin
            base_q <= align_base(wdata_i);
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign base_o   = base_q;

    assert_entry_save_R7: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (!status_q.glob_en && status_q.saved_en == $past(status_q.glob_en)));

    assert_eret_restore_R8: assert property (@(posedge clk) disable iff (rst)
        (eret_i && !take_i) |=> (status_q.glob_en == $past(status_q.saved_en)));

    assert_base_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i == CSR_BASE) |=> (base_q[ALIGN_BITS-1:0] == '0));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_pkg::*;
#(
    parameter int unsigned LINES = NUM_LINES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                boundary_i,
    input  logic                eret_i,
    input  irq_status_t         status_i,
    input  logic [LINES-1:0]    pend_i,
    input  logic [LINES-1:0]    mask_i,
    input  logic [XLEN-1:0]     base_i,
    input  logic [XLEN-1:0]     next_pc_i,
    input  logic [XLEN-1:0]     ea_value_i,
    output logic                take_o,
    output redirect_t           redirect_o,
    output logic                ea_we_o,
    output logic [RF_IDX_W-1:0] ea_idx_o,
    output logic [XLEN-1:0]     ea_wdata_o
);
    logic serviceable;

    assign serviceable = |(pend_i & mask_i);
    assign take_o      = boundary_i && status_i.glob_en && serviceable && !eret_i;

    always_comb begin
        redirect_o.valid  = take_o || eret_i;
        redirect_o.target = eret_i ? ea_value_i : (base_i + VECTOR_OFFSET);
    end

    assign ea_we_o    = take_o;
    assign ea_idx_o   = EA_REG_IDX;
    assign ea_wdata_o = next_pc_i;

    assert_take_gate_R4: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (boundary_i && (pend_i & mask_i) != '0));

    assert_vector_R5: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (redirect_o.target[ALIGN_BITS-1:0] == VECTOR_OFFSET[ALIGN_BITS-1:0]));

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         irq_req,
    input  logic                csr_we,
    input  logic [1:0]          csr_addr,
    input  logic [31:0]         csr_wdata,
    output logic [31:0]         csr_rdata,
    input  logic                insn_boundary,
    input  logic [31:0]         next_pc,
    input  logic                eret,
    input  logic [31:0]         ea_value,
    output logic                take_irq,
    output logic                redirect_valid,
    output logic [31:0]         redirect_pc,
    output logic                ea_we,
    output logic [4:0]          ea_idx,
    output logic [31:0]         ea_wdata
);
    csr_sel_e              sel;
    irq_status_t           status;
    logic [NUM_LINES-1:0]  mask;
    logic [NUM_LINES-1:0]  pend;
    logic [XLEN-1:0]       base;
    redirect_t             redir;
    logic                  take;

    assign sel = csr_sel_e'(csr_addr);

    irq_pending #(.LINES(NUM_LINES)) u_pending (
        .clk        (clk),
        .rst        (rst),
        .req_i      (irq_req),
        .clr_we_i   (csr_we && sel == CSR_PENDING),
        .clr_mask_i (csr_wdata[NUM_LINES-1:0]),
        .pend_o     (pend)
    );

    irq_csr_regs #(.LINES(NUM_LINES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_i     (csr_we),
        .sel_i    (sel),
        .wdata_i  (csr_wdata),
        .take_i   (take),
        .eret_i   (eret),
        .status_o (status),
        .mask_o   (mask),
        .base_o   (base)
    );

    irq_entry_seq #(.LINES(NUM_LINES)) u_entry (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (insn_boundary),
        .eret_i     (eret),
        .status_i   (status),
        .pend_i     (pend),
        .mask_i     (mask),
        .base_i     (base),
        .next_pc_i  (next_pc),
        .ea_value_i (ea_value),
        .take_o     (take),
        .redirect_o (redir),
        .ea_we_o    (ea_we),
        .ea_idx_o   (ea_idx),
        .ea_wdata_o (ea_wdata)
    );

    always_comb begin
        unique case (sel)
            CSR_STATUS:  csr_rdata = status_word(status);
            CSR_MASK:    csr_rdata = mask;
            CSR_PENDING: csr_rdata = pend;
            default:     csr_rdata = base;
        endcase
    end

    assign take_irq       = take;
    assign redirect_valid = redir.valid;
    assign redirect_pc    = redir.target;

    assert_ea_write_R6: assert property (@(posedge clk) disable iff (rst)
        ea_we |-> (ea_idx == 5'd30 && redirect_valid && !eret));

endmodule

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_req;
    logic        csr_we;
    logic [1:0]  csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        insn_boundary;
    logic [31:0] next_pc;
    logic        eret;
    logic [31:0] ea_value;
    logic        take_irq;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        ea_we;
    logic [4:0]  ea_idx;
    logic [31:0] ea_wdata;

    int checks = 0;
    int errors = 0;

    logic        m_gie, m_sie;
    logic [31:0] m_mask, m_pend, m_base;

    always #5 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .insn_boundary(insn_boundary), .next_pc(next_pc), .eret(eret),
        .ea_value(ea_value), .take_irq(take_irq), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .ea_we(ea_we), .ea_idx(ea_idx), .ea_wdata(ea_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {30'b0, m_sie, m_gie};
            2'd1:    return m_mask;
            2'd2:    return m_pend;
            default: return m_base;
        endcase
    endfunction

    function automatic logic exp_take(input logic bnd, input logic er);
        return bnd && m_gie && ((m_pend & m_mask) != 0) && !er;
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R7";
            2'd1:    return "R10";
            2'd2:    return "R2";
            default: return "R5";
        endcase
    endfunction

    task automatic step(input string tag, input logic [31:0] req, input logic we,
                        input logic [1:0] a, input logic [31:0] wd, input logic bnd,
                        input logic er, input logic [31:0] npc, input logic [31:0] ea);
        logic t;
        @(negedge clk);
        irq_req = req; csr_we = we; csr_addr = a; csr_wdata = wd;
        insn_boundary = bnd; eret = er; next_pc = npc; ea_value = ea;
        #1;
        t = exp_take(bnd, er);
        chk(tag == "" ? rd_tag(a) : tag, csr_rdata, exp_read(a));
        chk(tag == "" ? "R4" : tag, {31'b0, take_irq}, {31'b0, t});
        chk(tag == "" ? "R8" : tag, {31'b0, redirect_valid}, {31'b0, t || er});
        if (er) chk("R8", redirect_pc, ea);
        else if (t) chk("R5", redirect_pc, m_base + 32'hC0);
        chk("R6", {31'b0, ea_we}, {31'b0, t});
        if (t) begin
            chk("R6", {27'b0, ea_idx}, 32'd30);
            chk("R6", ea_wdata, npc);
        end
        @(posedge clk);
        m_pend = (m_pend & ~((we && a == 2'd2) ? wd : 32'h0)) | req;
        if (t) begin
            m_sie = m_gie; m_gie = 1'b0;
        end else if (er) begin
            m_gie = m_sie;
        end else if (we && a == 2'd0) begin
            m_gie = wd[0]; m_sie = wd[1];
        end
        if (we && a == 2'd1) m_mask = wd;
        if (we && a == 2'd3) m_base = {wd[31:8], 8'h00};
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        step(tag, 32'h0, 1'b0, a, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
        step(tag, 32'h0, 1'b1, a, d, 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        rst = 1'b1; irq_req = 0; csr_we = 0; csr_addr = 0; csr_wdata = 0;
        insn_boundary = 0; eret = 0; next_pc = 0; ea_value = 0;
        m_gie = 0; m_sie = 0; m_mask = 0; m_pend = 0; m_base = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset values of all four CSRs, and no take at a boundary
        for (int i = 0; i < 4; i++) rd("R1", i[1:0]);
        step("R1", 32'h0, 1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 32'h100, 32'h0);

        // R2 latch, R3 clear with the line still high, then a real clear
        step("R2", 32'h20, 1'b0, 2'd2, 0, 0, 0, 0, 0);
        rd("R2", 2'd2);
        step("R3", 32'h20, 1'b1, 2'd2, 32'h20, 0, 0, 0, 0);
        rd("R3", 2'd2);
        wr("R3", 2'd2, 32'h20);
        rd("R3", 2'd2);

        // R5 alignment and R10 full-width mask
        wr("R5", 2'd3, 32'h1234_5678);
        rd("R5", 2'd3);
        wr("R10", 2'd1, 32'hFFFF_FFFF);
        rd("R10", 2'd1);
        wr("R10", 2'd1, 32'h0000_0020);

        // R9: take coincides with a status write; the entry update wins
        step("R9", 32'h20, 1'b0, 2'd0, 0, 0, 0, 0, 0);
        wr("R9", 2'd0, 32'h1);
        step("R9", 32'h0, 1'b1, 2'd0, 32'h1, 1'b1, 1'b0, 32'h400, 32'h0);
        rd("R9", 2'd0);
        // R7: no nested entry while global enable is clear
        step("R7", 32'h0, 1'b0, 2'd0, 0, 1'b1, 1'b0, 32'h404, 32'h0);
        // R8: return restores enable; then return beats a boundary take
        step("R8", 32'h0, 1'b0, 2'd0, 0, 1'b0, 1'b1, 32'h0, 32'h400);
        rd("R8", 2'd0);
        step("R8", 32'h0, 1'b1, 2'd0, 32'h0, 1'b1, 1'b1, 32'h500, 32'h888);
        rd("R8", 2'd0);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            r = $urandom;
            step("",
                 (r[2:0] == 0) ? (32'h1 << $urandom_range(31)) : 32'h0,
                 r[5:3] == 0, r[7:6],
                 (r[7:6] == 2'd0) ? {30'b0, r[9], (r[11:10] != 0)} :
                 (r[7:6] == 2'd1) ? (($urandom % 4 == 0) ? 32'h0 : $urandom) : $urandom,
                 r[13:12] != 0, r[18:14] == 0, $urandom, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule